// File: doc/BRIEF.md
# Single-Slot Task Request Mailbox

This block passes one start address from a requesting agent to a background worker task. It keeps a single slot word. The top bit of that word is the pending flag and the lower bits hold the start address. A request reads and sets the flag in one step. If the slot was free, the address is stored, the worker gets a wake pulse and the requester sees a nonzero status. If a request is already waiting, the requester sees a zero status and the stored address stays as it was. A full slot makes a request fail; it does not make it wait.

The worker side is a two-state machine. In `W_IDLE` the worker is blocked. When the slot holds a pending entry, the *accept* transition takes the address as the next start point, clears the slot to zero and moves to `W_RUN`. In `W_RUN` the worker executes until `wk_done`. The *finish* transition then returns it to `W_IDLE`, where it checks the slot again. If a request and an accept fall in the same cycle, the accept is applied first, so the new request finds the slot free and succeeds.

Top module: `task_mailbox`

## Requirements
- R1: After reset, `req_ack`, `req_status`, `wk_wake`, `wk_start` and `wk_busy` are all zero.
- R2: A request that finds the slot free is answered one cycle after it is sampled. The answer is `req_ack`=1 with `req_status` = {1'b1, req_addr}, so bit 15 is set and bits 14:0 carry the address. `wk_wake` pulses in that same cycle. The status is nonzero even for address 0.
- R3: A request that finds a pending entry not being accepted in that cycle is answered with `req_ack`=1 and `req_status`=0. No wake pulse is issued.
- R4: A failed request leaves the stored address unchanged. The worker later starts at the address of the earlier successful request.
- R5: A worker in `W_IDLE` that sees a pending entry at a clock edge accepts it at that edge. One cycle later `wk_start` pulses for one cycle, `wk_start_addr` holds the stored address and `wk_busy` is 1. The slot is then empty.
- R6: When a request is sampled at the same edge as an accept, the request succeeds and its address becomes the next pending entry.
- R7: In `W_RUN`, `wk_busy` stays 1 until `wk_done` is sampled, and then drops one cycle later. `wk_done` while in `W_IDLE` has no effect.
- R8: `req_ack` rises only one cycle after a sampled `req_valid`. `wk_wake` rises only together with a successful acknowledgement.
- R9: With no pending entry, the worker stays blocked: `wk_busy`=0 and no `wk_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_addr | input | 15 | Requested start address |
| req_ack | output | 1 | Request answered (one cycle) |
| req_status | output | 16 | Zero on failure; {1, addr} on success |
| wk_wake | output | 1 | One-cycle wake pulse to the worker |
| wk_start | output | 1 | One-cycle pulse: worker starts at wk_start_addr |
| wk_start_addr | output | 15 | Start address taken from the slot |
| wk_busy | output | 1 | Worker is in W_RUN |
| wk_done | input | 1 | Worker finished its routine |

## Verification
The bench aims a request at the exact edge where the idle worker accepts the previous entry. A design that tested the flag before clearing it would reject that request and return zero status. It sends two requests while an entry is pending and the worker is busy. A design that overwrote the slot would start the worker at the rejected address instead of the earlier one. Address 0 and the all-ones address probe the status encoding: a design that returned the raw address as status would report success with zero. A done pulse given while the worker is idle must not start anything. A worker that woke without a pending entry would produce an unexpected start, which the monitor flags.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    typedef enum logic [0:0] {
        W_IDLE = 1'b0,
        W_RUN  = 1'b1
    } wk_state_t;
endpackage

// File: rtl/mbox_slot.sv
module mbox_slot #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              accept,
    output logic              pending,
    output logic [ADDR_W-1:0] slot_addr,
    output logic              grant
);
    localparam int SLOT_W = ADDR_W + 1;

    logic [SLOT_W-1:0] slot_q;
    logic              busy_eff;

    assign pending   = slot_q[SLOT_W-1];
    assign slot_addr = slot_q[ADDR_W-1:0];

    // accept takes effect before the test-and-set of a same-cycle request
    assign busy_eff = pending & ~accept;
    assign grant    = req_valid & ~busy_eff;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (grant) begin
            slot_q <= {1'b1, req_addr};
        end else if (accept) begin
            slot_q <= '0;
        end
    end
endmodule

// File: rtl/mbox_worker.sv
module mbox_worker
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pending,
    input  logic [ADDR_W-1:0] slot_addr,
    input  logic              done,
    output logic              accept,
    output logic              start,
    output logic [ADDR_W-1:0] start_addr,
    output logic              busy
);
    wk_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE: if (pending) state_d = W_RUN;
            W_RUN:  if (done)    state_d = W_IDLE;
            default:             state_d = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    assign accept = (state_q == W_IDLE) && pending;
    assign busy   = (state_q == W_RUN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start      <= 1'b0;
            start_addr <= '0;
        end else begin
            start <= accept;
            if (accept) start_addr <= slot_addr;
        end
    end
endmodule

// File: rtl/mbox_resp.sv
module mbox_resp #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              grant,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              ack,
    output logic [ADDR_W:0]   status,
    output logic              wake
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack    <= 1'b0;
            status <= '0;
            wake   <= 1'b0;
        end else begin
            ack    <= req_valid;
            wake   <= grant;
            status <= grant ? {1'b1, req_addr} : '0;
        end
    end
endmodule

// File: rtl/task_mailbox.sv
module task_mailbox #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ack,
    output logic [ADDR_W:0]   req_status,
    output logic              wk_wake,
    output logic              wk_start,
    output logic [ADDR_W-1:0] wk_start_addr,
    output logic              wk_busy,
    input  logic              wk_done
);
    logic              pending;
    logic [ADDR_W-1:0] slot_addr;
    logic              grant;
    logic              accept;

    mbox_slot #(.ADDR_W(ADDR_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .accept    (accept),
        .pending   (pending),
        .slot_addr (slot_addr),
        .grant     (grant)
    );

    mbox_worker #(.ADDR_W(ADDR_W)) u_worker (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending    (pending),
        .slot_addr  (slot_addr),
        .done       (wk_done),
        .accept     (accept),
        .start      (wk_start),
        .start_addr (wk_start_addr),
        .busy       (wk_busy)
    );

    mbox_resp #(.ADDR_W(ADDR_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .grant     (grant),
        .req_addr  (req_addr),
        .ack       (req_ack),
        .status    (req_status),
        .wake      (wk_wake)
    );
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ack,
    input logic [ADDR_W:0]   req_status,
    input logic              wk_wake,
    input logic              wk_start,
    input logic              wk_busy,
    input logic              wk_done,
    input logic              pending
);
    AST_WAKE_WITH_OK: assert property (@(posedge clk) disable iff (!rst_n)
        wk_wake |-> (req_ack && req_status[ADDR_W])); // R2
    AST_FAIL_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ack && !req_status[ADDR_W]) |-> (req_status == '0)); // R3
    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ack) |-> $past(req_valid)); // R8
    AST_START_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        wk_start |=> !wk_start); // R5
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wk_start |-> wk_busy); // R5
    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_busy && !wk_done) |=> wk_busy); // R7
    AST_IDLE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wk_busy && !pending) |=> !wk_start); // R9
endmodule

bind task_mailbox mbox_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ack    (req_ack),
    .req_status (req_status),
    .wk_wake    (wk_wake),
    .wk_start   (wk_start),
    .wk_busy    (wk_busy),
    .wk_done    (wk_done),
    .pending    (pending)
);

// File: tb/test_task_mailbox.sv
module test_task_mailbox;
    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ack;
    logic [AW:0]   req_status;
    logic          wk_wake;
    logic          wk_start;
    logic [AW-1:0] wk_start_addr;
    logic          wk_busy;
    logic          wk_done = 1'b0;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [AW:0]   exp_ack_q[$];
    logic [AW-1:0] exp_start_q[$];

    always #2 clk = ~clk;

    task_mailbox #(.ADDR_W(AW)) i_task_mailbox (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ack(req_ack), .req_status(req_status), .wk_wake(wk_wake),
        .wk_start(wk_start), .wk_start_addr(wk_start_addr), .wk_busy(wk_busy),
        .wk_done(wk_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: called at a falling edge, holds the request for one cycle
    task automatic issue(input logic [AW-1:0] a, input bit ok);
        req_valid = 1'b1;
        req_addr  = a;
        exp_ack_q.push_back(ok ? {1'b1, a} : '0);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse_done();
        wk_done = 1'b1;
        @(negedge clk);
        wk_done = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (req_ack) begin
                if (exp_ack_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected ack", 1, 0);
                end else begin
                    logic [AW:0] e;
                    e = exp_ack_q.pop_front();
                    chk(req_status == e, e[AW] ? "R2/R6 status" : "R3 status",
                        int'(req_status), int'(e));
                end
            end
            if (req_ack || wk_wake)
                chk(wk_wake == (req_ack && req_status[AW]), "R8 wake",
                    int'(wk_wake), int'(req_ack && req_status[AW]));
            if (wk_start) begin
                if (exp_start_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected start", int'(wk_start_addr), 0);
                end else begin
                    logic [AW-1:0] s;
                    s = exp_start_q.pop_front();
                    chk(wk_start_addr == s && wk_busy, "R4/R5 start addr",
                        int'(wk_start_addr), int'(s));
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!req_ack && req_status == '0 && !wk_wake && !wk_start && !wk_busy,
            "R1 reset outputs", int'({req_ack, wk_wake, wk_start, wk_busy}), 0);
        repeat (3) @(negedge clk);
        chk(!wk_busy, "R9 blocked with empty slot", int'(wk_busy), 0);

        // R2 then R6: second request lands on the accept edge
        exp_start_q.push_back(15'h1234);
        exp_start_q.push_back(15'h0456);
        issue(15'h1234, 1'b1);
        issue(15'h0456, 1'b1);
        // R3/R4: worker busy, slot pending -> both rejected
        issue(15'h7777, 1'b0);
        issue(15'h0001, 1'b0);
        chk(wk_busy, "R7 busy while running", int'(wk_busy), 1);
        repeat (4) @(negedge clk);
        chk(wk_busy, "R7 busy held without done", int'(wk_busy), 1);
        pulse_done();
        chk(!wk_busy, "R7 idle after done", int'(wk_busy), 0);
        @(negedge clk);
        chk(wk_busy, "R4 second entry accepted", int'(wk_busy), 1);
        pulse_done();
        repeat (5) @(negedge clk);
        chk(!wk_busy, "R9 blocked after drain", int'(wk_busy), 0);

        // R7: done in idle has no effect
        pulse_done();
        repeat (3) @(negedge clk);
        chk(!wk_busy, "R7 done ignored in idle", int'(wk_busy), 0);

        // R2 boundary addresses
        exp_start_q.push_back(15'h0000);
        issue(15'h0000, 1'b1);
        repeat (2) @(negedge clk);
        pulse_done();
        @(negedge clk);
        exp_start_q.push_back(15'h7FFF);
        exp_start_q.push_back(15'h2AAA);
        issue(15'h7FFF, 1'b1);
        @(negedge clk);
        issue(15'h2AAA, 1'b1);
        issue(15'h5555, 1'b0);
        pulse_done();
        @(negedge clk);
        pulse_done();
        repeat (4) @(negedge clk);
        chk(!wk_busy, "R9 idle at end", int'(wk_busy), 0);
        chk(exp_ack_q.size() == 0, "R8 all requests answered", exp_ack_q.size(), 0);
        chk(exp_start_q.size() == 0, "R5 all starts seen", exp_start_q.size(), 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule